// File: doc/BRIEF.md
# Configuration address/data port bridge

This block sits between a host I/O-port bus and a configuration-space fabric. The host sees two 4-byte windows. One is a pointer port that holds a bus, device, function and register-offset selector, together with an enable flag. The other is a data port. Every access to the data port turns into a dword-wide downstream read or write aimed at the selected function.

The host may use byte, word or dword accesses on either window. A narrow read returns the addressed lanes of the dword. A narrow data write becomes a three-step sequence: the bridge reads the current dword, merges the new bytes into the addressed lanes, and writes the whole dword back.

The downstream side uses a valid/ready request and a single response beat that carries a status code. Either phase may stall. Only one host access is handled at a time. The host holds its request until the bridge pulses `host_ready` for one cycle with the result. Misses, disabled accesses and downstream errors all complete normally and return fixed fill values. Malformed host accesses are rejected with a status code.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the pointer register is zero, so its enable flag (bit 31) is clear. `host_ready` and `dn_req_valid` are low until a host access arrives.
- R2: An access is rejected in the following priority order. A size other than 1, 2 or 4 gives `host_status` 1. A read that is misaligned gives status 2: a dword read needs port bits 1:0 = 0, and a word read needs port bit 0 = 0. A port outside both windows gives status 3. A rejected access returns `host_rdata` = 0 and issues no downstream request. Accepted accesses report status 0.
- R3: A write to the pointer window updates the pointer register. A dword write replaces bits 31:0, a word write replaces bits 15:0 and a byte write replaces bits 7:0, whatever the lane. Bits 1:0 and 30:24 are then stored as zero. Reading the pointer window returns the stored value.
- R4: A narrow read returns the source dword shifted right by 8 × (port bits 1:0), then masked to 8 or 16 bits. This applies to both windows.
- R5: While the enable flag is clear, a data read returns all ones masked to the access size, and a data write is dropped. Neither issues a downstream request.
- R6: A data read issues one downstream read. The pointer fields are: offset = bits 7:0, function = bits 10:8, device = bits 15:11, bus = bits 23:16. The response status decides the result: 0 (OK) returns the lane-shifted data, 1 (ERROR) returns zero, and 2 (NOT_PRESENT) returns all ones masked to the size.
- R7: A dword data write issues exactly one downstream write carrying the host data. Its response status is ignored and the host sees status 0.
- R8: A byte or word data write first reads the dword, then writes back the merged value: the old value with the addressed lanes replaced by the new bytes. An ERROR on that read uses zero as the old value. A NOT_PRESENT on that read drops the write.
- R9: `host_ready` is a one-cycle pulse, and no new host request is taken before it.
- R10: While the downstream request or response is stalled, the request fields stay constant and `host_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| host_valid | input | 1 | Host access pending, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_port | input | 16 | I/O port byte address |
| host_size | input | 3 | Access size in bytes |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, right-aligned |
| host_status | output | 2 | 0 ok, 1 bad size, 2 unaligned, 3 bad port |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 = write request |
| dn_req_bus | output | 8 | Target bus number |
| dn_req_dev | output | 5 | Target device number |
| dn_req_fn | output | 3 | Target function number |
| dn_req_off | output | 8 | Dword-aligned register offset |
| dn_req_wdata | output | 32 | Write data |
| dn_rsp_valid | input | 1 | Downstream response beat |
| dn_rsp_status | input | 2 | 0 ok, 1 error, 2 not present |
| dn_rsp_rdata | input | 32 | Read data |

## Verification
The assertions assume that the host keeps `host_valid` and its fields steady from issue until the `host_ready` pulse. They also assume that the fabric returns exactly one `dn_rsp_valid` beat per accepted request, never before acceptance. The bench host task changes inputs only on falling edges and lowers `host_valid` in the cycle it sees the pulse. The downstream model acknowledges only a request it has seen pending, and it answers once, after a programmable stall.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    HST_OK        = 2'd0,
    HST_BAD_SIZE  = 2'd1,
    HST_UNALIGNED = 2'd2,
    HST_BAD_PORT  = 2'd3
  } host_st_e;

  typedef enum logic [1:0] {
    DST_OK     = 2'd0,
    DST_ERROR  = 2'd1,
    DST_ABSENT = 2'd2
  } dn_st_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_READ_WAIT  = 3'd1,
    ST_MERGE_WAIT = 3'd2,
    ST_WRITE_WAIT = 3'd3,
    ST_RESPOND    = 3'd4
  } ctl_st_e;

  function automatic logic [DW-1:0] size_mask(input logic [2:0] size);
    case (size)
      3'd1:    size_mask = 32'h0000_00FF;
      3'd2:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_extract(input logic [DW-1:0] v,
                                                 input logic [1:0] lane,
                                                 input logic [2:0] size);
    lane_extract = (v >> {lane, 3'b000}) & size_mask(size);
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [1:0] lane,
                                               input logic [2:0] size);
    logic [DW-1:0] m;
    m = size_mask(size);
    lane_merge = (old_v & ~(m << {lane, 3'b000})) | ((new_v & m) << {lane, 3'b000});
  endfunction
endpackage

// File: rtl/cfgb_access_check.sv
module cfgb_access_check
  import cfgb_pkg::*;
#(
  parameter int              PORT_W    = 16,
  parameter logic [PORT_W-1:0] PTR_BASE  = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_BASE = 16'h0CFC
) (
  input  logic              is_write,
  input  logic [PORT_W-1:0] port,
  input  logic [2:0]        size,
  output host_st_e          verdict,
  output logic              hit_ptr
);
  logic size_ok, align_ok, hit_data;

  always_comb begin
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    align_ok = is_write || (size == 3'd1) ||
               ((size == 3'd2) && !port[0]) ||
               ((size == 3'd4) && (port[1:0] == 2'b00));
    hit_ptr  = (port[PORT_W-1:2] == PTR_BASE[PORT_W-1:2]);
    hit_data = (port[PORT_W-1:2] == DATA_BASE[PORT_W-1:2]);
    if (!size_ok)                  verdict = HST_BAD_SIZE;
    else if (!align_ok)            verdict = HST_UNALIGNED;
    else if (!hit_ptr && !hit_data) verdict = HST_BAD_PORT;
    else                           verdict = HST_OK;
  end
endmodule

// File: rtl/cfgb_ptr_reg.sv
module cfgb_ptr_reg
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ptr_q
);
  logic [DW-1:0] merged, ptr_d;

  always_comb begin
    case (wr_size)
      3'd4:    merged = wr_data;
      3'd2:    merged = {ptr_q[31:16], wr_data[15:0]};
      default: merged = {ptr_q[31:8], wr_data[7:0]};
    endcase
    ptr_d = {merged[31], 7'b0, merged[23:2], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_d;
  end

  // R3: the cleared fields never hold a one
  a_r3_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q[30:24] == 7'd0) && (ptr_q[1:0] == 2'b00));
  // R3: the register only moves on a pointer-window write
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_write,
  input  logic [1:0]    host_lane,
  input  logic [2:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  input  host_st_e      verdict,
  input  logic          hit_ptr,
  input  logic [DW-1:0] ptr_q,
  output logic          ptr_wr_en,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic [1:0]    host_status,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic          dn_req_write,
  output logic [DW-1:0] dn_req_wdata,
  input  logic          dn_rsp_valid,
  input  logic [1:0]    dn_rsp_status,
  input  logic [DW-1:0] dn_rsp_rdata
);
  ctl_st_e       state_q, state_d;
  logic [1:0]    lane_q, lane_d;
  logic [2:0]    size_q, size_d;
  logic [DW-1:0] new_q, new_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] result_q, result_d;
  host_st_e      hstat_q, hstat_d;
  logic          acc_q, acc_d;
  logic          rsp_take, waiting;

  always_comb begin
    waiting  = (state_q == ST_READ_WAIT) || (state_q == ST_MERGE_WAIT) ||
               (state_q == ST_WRITE_WAIT);
    rsp_take = acc_q && dn_rsp_valid;
  end

  always_comb begin
    state_d   = state_q;
    lane_d    = lane_q;
    size_d    = size_q;
    new_d     = new_q;
    wdata_d   = wdata_q;
    result_d  = result_q;
    hstat_d   = hstat_q;
    ptr_wr_en = 1'b0;
    case (state_q)
      ST_IDLE: if (host_valid) begin
        lane_d   = host_lane;
        size_d   = host_size;
        new_d    = host_wdata;
        result_d = '0;
        hstat_d  = verdict;
        state_d  = ST_RESPOND;
        if (verdict == HST_OK) begin
          if (hit_ptr) begin
            if (host_write) ptr_wr_en = 1'b1;
            else            result_d = lane_extract(ptr_q, host_lane, host_size);
          end else if (!ptr_q[31]) begin
            if (!host_write) result_d = size_mask(host_size);
          end else if (!host_write) begin
            state_d = ST_READ_WAIT;
          end else if (host_size == 3'd4) begin
            wdata_d = host_wdata;
            state_d = ST_WRITE_WAIT;
          end else begin
            state_d = ST_MERGE_WAIT;
          end
        end
      end
      ST_READ_WAIT: if (rsp_take) begin
        case (dn_rsp_status)
          DST_OK:     result_d = lane_extract(dn_rsp_rdata, lane_q, size_q);
          DST_ABSENT: result_d = size_mask(size_q);
          default:    result_d = '0;
        endcase
        state_d = ST_RESPOND;
      end
      ST_MERGE_WAIT: if (rsp_take) begin
        if (dn_rsp_status == DST_ABSENT) begin
          state_d = ST_RESPOND;
        end else begin
          wdata_d = lane_merge((dn_rsp_status == DST_OK) ? dn_rsp_rdata : '0,
                               new_q, lane_q, size_q);
          state_d = ST_WRITE_WAIT;
        end
      end
      ST_WRITE_WAIT: if (rsp_take) state_d = ST_RESPOND;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    acc_d = acc_q;
    if (dn_req_valid && dn_req_ready) acc_d = 1'b1;
    else if (rsp_take)                acc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lane_q   <= '0;
      size_q   <= '0;
      new_q    <= '0;
      wdata_q  <= '0;
      result_q <= '0;
      hstat_q  <= HST_OK;
      acc_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      lane_q   <= lane_d;
      size_q   <= size_d;
      new_q    <= new_d;
      wdata_q  <= wdata_d;
      result_q <= result_d;
      hstat_q  <= hstat_d;
      acc_q    <= acc_d;
    end
  end

  always_comb begin
    host_ready   = (state_q == ST_RESPOND);
    host_rdata   = result_q;
    host_status  = hstat_q;
    dn_req_valid = waiting && !acc_q;
    dn_req_write = (state_q == ST_WRITE_WAIT);
    dn_req_wdata = wdata_q;
  end

  // R9: completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  // R10: a stalled request keeps its kind and data
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=>
      dn_req_valid && $stable(dn_req_write) && $stable(dn_req_wdata));
  // R2: a rejected access returns zero data
  a_r2_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready && (host_status != 2'd0) |-> host_rdata == '0);
  // R10: the host is not answered while a request is still pending downstream
  a_r10_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !host_ready);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int                PORT_W    = 16,
  parameter logic [PORT_W-1:0] PTR_BASE  = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_BASE = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [PORT_W-1:0] host_port,
  input  logic [2:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  output logic [31:0]       host_rdata,
  output logic [1:0]        host_status,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [7:0]        dn_req_bus,
  output logic [4:0]        dn_req_dev,
  output logic [2:0]        dn_req_fn,
  output logic [7:0]        dn_req_off,
  output logic [31:0]       dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic [1:0]        dn_rsp_status,
  input  logic [31:0]       dn_rsp_rdata
);
  host_st_e      verdict;
  logic          hit_ptr, ptr_wr_en;
  logic [DW-1:0] ptr_q;

  cfgb_access_check #(
    .PORT_W(PORT_W), .PTR_BASE(PTR_BASE), .DATA_BASE(DATA_BASE)
  ) u_check (
    .is_write(host_write), .port(host_port), .size(host_size),
    .verdict(verdict), .hit_ptr(hit_ptr)
  );

  cfgb_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr_en), .wr_size(host_size),
    .wr_data(host_wdata), .ptr_q(ptr_q)
  );

  cfgb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_lane(host_port[1:0]),
    .host_size(host_size), .host_wdata(host_wdata),
    .verdict(verdict), .hit_ptr(hit_ptr), .ptr_q(ptr_q), .ptr_wr_en(ptr_wr_en),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_status(host_status),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_status(dn_rsp_status),
    .dn_rsp_rdata(dn_rsp_rdata)
  );

  always_comb begin
    dn_req_off = {ptr_q[7:2], 2'b00};
    dn_req_fn  = ptr_q[10:8];
    dn_req_dev = ptr_q[15:11];
    dn_req_bus = ptr_q[23:16];
  end

  // R6: downstream offsets are always dword aligned
  a_r6_off_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> dn_req_off[1:0] == 2'b00);
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic [15:0] host_port;
  logic [2:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic [1:0]  host_status;
  logic        dn_req_valid, dn_req_ready, dn_req_write;
  logic [7:0]  dn_req_bus, dn_req_off;
  logic [4:0]  dn_req_dev;
  logic [2:0]  dn_req_fn;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid;
  logic [1:0]  dn_rsp_status;
  logic [31:0] dn_rsp_rdata;

  always #2 clk = ~clk;

  cfg_port_bridge dut_i (.*);

  int tests = 0, fails = 0;
  // downstream model controls and records
  int          req_dly = 0, rsp_dly = 0;
  logic [1:0]  m_rd_st = 2'd0, m_wr_st = 2'd0;
  logic [31:0] m_rd_data = '0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] last_wd;
  logic [7:0]  last_bus, last_off;
  logic [4:0]  last_dev;
  logic [2:0]  last_fn;

  initial begin
    dn_req_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_status = 2'd0; dn_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      dn_req_ready = 1'b0; dn_rsp_valid = 1'b0;
      if (dn_req_valid) begin
        repeat (req_dly) @(negedge clk);
        dn_req_ready = 1'b1;
        last_bus = dn_req_bus; last_dev = dn_req_dev; last_fn = dn_req_fn; last_off = dn_req_off;
        if (dn_req_write) begin n_wr++; last_wd = dn_req_wdata; dn_rsp_status = m_wr_st; end
        else begin n_rd++; dn_rsp_status = m_rd_st; end
        dn_rsp_rdata = m_rd_data;
        @(negedge clk);
        dn_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        dn_rsp_valid = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] port, input logic [2:0] size,
                        input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] st,
                        output int cyc);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    host_valid = 1'b1; host_write = wr; host_port = port; host_size = size; host_wdata = wd;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!host_ready && cyc < 1000);
    rd = host_rdata; st = host_status;
    host_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] port;
    logic [2:0]  size;
    logic [31:0] wd;
    logic [1:0]  rs;
    logic [31:0] rdv;
    logic [1:0]  ws;
    logic [1:0]  est;
    logic [31:0] erd;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [31:0] ewd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VT [NV] = '{
    '{1'b1, 16'h0CF8, 3'd4, 32'hFF12_AB67, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd3},        // R3 fixup
    '{1'b0, 16'h0CF8, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h8012_AB64, 4'd0, 4'd0, 32'h0, 4'd3},        // R3 readback
    '{1'b0, 16'h0CFA, 3'd2, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0000_8012, 4'd0, 4'd0, 32'h0, 4'd4},        // R4
    '{1'b0, 16'h0CF9, 3'd1, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0000_00AB, 4'd0, 4'd0, 32'h0, 4'd4},        // R4
    '{1'b1, 16'h0CF8, 3'd1, 32'hFFFF_FF3B, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd3},        // R3 byte
    '{1'b0, 16'h0CF8, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h8012_AB38, 4'd0, 4'd0, 32'h0, 4'd3},        // R3
    '{1'b1, 16'h0CFB, 3'd2, 32'hEEEE_1A07, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd3},        // R3 word
    '{1'b0, 16'h0CFC, 3'd4, 32'h0, 2'd0, 32'hDEAD_BEEF, 2'd0, 2'd0, 32'hDEAD_BEEF, 4'd1, 4'd0, 32'h0, 4'd6}, // R6 ok
    '{1'b0, 16'h0CFE, 3'd2, 32'h0, 2'd0, 32'hDEAD_BEEF, 2'd0, 2'd0, 32'h0000_DEAD, 4'd1, 4'd0, 32'h0, 4'd4}, // R4
    '{1'b0, 16'h0CFD, 3'd1, 32'h0, 2'd0, 32'hDEAD_BEEF, 2'd0, 2'd0, 32'h0000_00BE, 4'd1, 4'd0, 32'h0, 4'd4}, // R4
    '{1'b0, 16'h0CFC, 3'd4, 32'h0, 2'd1, 32'hDEAD_BEEF, 2'd0, 2'd0, 32'h0, 4'd1, 4'd0, 32'h0, 4'd6},         // R6 error
    '{1'b0, 16'h0CFF, 3'd1, 32'h0, 2'd2, 32'h1234_5678, 2'd0, 2'd0, 32'h0000_00FF, 4'd1, 4'd0, 32'h0, 4'd6}, // R6 absent
    '{1'b1, 16'h0CFC, 3'd4, 32'h1122_3344, 2'd0, 32'h0, 2'd1, 2'd0, 32'h0, 4'd0, 4'd1, 32'h1122_3344, 4'd7}, // R7
    '{1'b1, 16'h0CFD, 3'd1, 32'h0000_00A5, 2'd0, 32'h1122_3344, 2'd0, 2'd0, 32'h0, 4'd1, 4'd1, 32'h1122_A544, 4'd8}, // R8
    '{1'b1, 16'h0CFE, 3'd2, 32'hFFFF_BEEF, 2'd0, 32'h1122_3344, 2'd0, 2'd0, 32'h0, 4'd1, 4'd1, 32'hBEEF_3344, 4'd8}, // R8
    '{1'b1, 16'h0CFF, 3'd1, 32'h0000_0077, 2'd1, 32'h1122_3344, 2'd0, 2'd0, 32'h0, 4'd1, 4'd1, 32'h7700_0000, 4'd8}, // R8 err
    '{1'b1, 16'h0CFC, 3'd2, 32'h0000_55AA, 2'd2, 32'h1122_3344, 2'd0, 2'd0, 32'h0, 4'd1, 4'd0, 32'h0, 4'd8},  // R8 absent
    '{1'b0, 16'h0CFD, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd2, 32'h0, 4'd0, 4'd0, 32'h0, 4'd2},                 // R2
    '{1'b0, 16'h0CFD, 3'd2, 32'h0, 2'd0, 32'h0, 2'd0, 2'd2, 32'h0, 4'd0, 4'd0, 32'h0, 4'd2},                 // R2
    '{1'b0, 16'h0CFC, 3'd3, 32'h0, 2'd0, 32'h0, 2'd0, 2'd1, 32'h0, 4'd0, 4'd0, 32'h0, 4'd2},                 // R2
    '{1'b0, 16'h0D00, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd3, 32'h0, 4'd0, 4'd0, 32'h0, 4'd2},                 // R2
    '{1'b1, 16'h0CF4, 3'd4, 32'hFFFF_FFFF, 2'd0, 32'h0, 2'd0, 2'd3, 32'h0, 4'd0, 4'd0, 32'h0, 4'd2},         // R2
    '{1'b1, 16'h0CF8, 3'd4, 32'h0012_AB64, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd3},         // R3 disable
    '{1'b0, 16'h0CFC, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'hFFFF_FFFF, 4'd0, 4'd0, 32'h0, 4'd5},         // R5
    '{1'b0, 16'h0CFE, 3'd2, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0000_FFFF, 4'd0, 4'd0, 32'h0, 4'd5},         // R5
    '{1'b1, 16'h0CFC, 3'd4, 32'h1234_5678, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd5},         // R5
    '{1'b1, 16'h0CFD, 3'd1, 32'h0000_0099, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0, 4'd0, 4'd0, 32'h0, 4'd5},         // R5
    '{1'b0, 16'h0CF8, 3'd4, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, 32'h0012_AB64, 4'd0, 4'd0, 32'h0, 4'd3}          // R3
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  st;
    int          cyc;
    string       tag;
    host_valid = 1'b0; host_write = 1'b0; host_port = '0; host_size = 3'd4; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {31'b0, host_ready}, 32'h0);
    chk("R1", "req valid after reset", {31'b0, dn_req_valid}, 32'h0);
    access(1'b0, 16'h0CF8, 3'd4, 32'h0, rd, st, cyc);
    chk("R1", "pointer after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      m_rd_st = VT[i].rs; m_rd_data = VT[i].rdv; m_wr_st = VT[i].ws;
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      access(VT[i].wr, VT[i].port, VT[i].size, VT[i].wd, rd, st, cyc);
      repeat (2) @(negedge clk);
      chk(tag, "status", {30'b0, st}, {30'b0, VT[i].est});
      chk(tag, "rdata", rd, VT[i].erd);
      chk(tag, "reads", n_rd, {28'b0, VT[i].nrd});
      chk(tag, "writes", n_wr, {28'b0, VT[i].nwr});
      if (VT[i].nwr != 0) chk(tag, "write data", last_wd, VT[i].ewd);
    end

    // R6: field decode of the pointer onto the request
    access(1'b1, 16'h0CF8, 3'd4, 32'hFFFF_FFFF, rd, st, cyc);
    m_rd_st = 2'd0; m_rd_data = 32'hCAFE_0001;
    access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, st, cyc);
    chk("R6", "bus", {24'b0, last_bus}, 32'hFF);
    chk("R6", "dev", {27'b0, last_dev}, 32'h1F);
    chk("R6", "fn", {29'b0, last_fn}, 32'h7);
    chk("R6", "off", {24'b0, last_off}, 32'hFC);
    access(1'b1, 16'h0CF8, 3'd4, 32'h8012_1A04, rd, st, cyc);
    access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, st, cyc);
    chk("R6", "bus b", {24'b0, last_bus}, 32'h12);
    chk("R6", "dev b", {27'b0, last_dev}, 32'h03);
    chk("R6", "fn b", {29'b0, last_fn}, 32'h2);
    chk("R6", "off b", {24'b0, last_off}, 32'h04);

    // R9: one-cycle ready pulse
    @(negedge clk);
    chk("R9", "ready after pulse", {31'b0, host_ready}, 32'h0);

    // R10: stalled request and response
    req_dly = 5; rsp_dly = 7; m_rd_data = 32'h0BAD_F00D;
    access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, st, cyc);
    chk("R10", "stalled read data", rd, 32'h0BAD_F00D);
    chk("R10", "stall latency >= 13", {31'b0, (cyc >= 13)}, 32'h1);
    access(1'b1, 16'h0CFE, 3'd2, 32'h0000_1234, rd, st, cyc);
    chk("R10", "stalled merge data", last_wd, 32'h1234_F00D);
    chk("R10", "stalled merge reads", n_rd, 32'd1);
    req_dly = 0; rsp_dly = 0;

    // R1: reset mid-run clears the pointer and its enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 16'h0CF8, 3'd4, 32'h0, rd, st, cyc);
    chk("R1", "pointer after second reset", rd, 32'h0);
    access(1'b0, 16'h0CFC, 3'd4, 32'h0, rd, st, cyc);
    repeat (2) @(negedge clk);
    chk("R1", "disabled data read", rd, 32'hFFFF_FFFF);
    chk("R1", "no downstream read", n_rd, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule